// File: doc/BRIEF.md
# Half-Rate Pseudo-Random Pattern Source (period 2047)

This block produces a maximal-length pseudo-random bit pattern of 2047 bits at the full line rate while its register runs on a clock at half that rate. An 11-stage shift register with XOR feedback implements x^11 + x^9 + 1. The register advances two sequence positions on each clock edge and presents an even bit and an odd bit. A 2:1 selector steered by the clock level interleaves the two bits into one serial stream. That stream has the same bit order as a serial generator clocked at full rate.

Two outputs support lab equipment. A trigger marks the cycle in which the register holds its seed again, so an oscilloscope or error counter can lock to the pattern. A monitor output gives a retimed copy of the even stream at half rate. An active-low asynchronous reset loads the all-ones seed, which keeps the register clear of the all-zero lockup state.

Top module: `prbs_hr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, even_o = 1, odd_o = 1, trig_o = 1 and mon_o = 0.
- R2: Number the sequence bits b[0], b[1], ... with b[0..10] = 1 and b[n+11] = b[n] ^ b[n+2]. In half-rate cycle k (cycle 0 is the cycle after reset release), even_o = b[2k] and odd_o = b[2k+1].
- R3: ser_o equals even_o while clk_i is high and odd_o while clk_i is low, so the serial order is b[0], b[1], b[2], ...
- R4: The sequence repeats every 2047 bits: b[n+2047] = b[n]. In particular, in cycle 1023 odd_o = b[2047] = 1. The register never holds all zeros.
- R5: trig_o is high for exactly one cycle at cycle 0 and then every 2047 cycles. That span is two pattern periods.
- R6: mon_o in cycle k+1 equals even_o of cycle k.
- R7: Asserting reset in the middle of a run returns the outputs to the R1 values at once, without waiting for a clock edge, and the sequence restarts at b[0] after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-rate clock; its level also steers the serial selector |
| rst_ni | input | 1 | Active-low asynchronous reset, loads the all-ones seed |
| even_o | output | 1 | Even-position sequence bit of the current cycle |
| odd_o | output | 1 | Odd-position sequence bit of the current cycle |
| ser_o | output | 1 | Full-rate interleaved serial bit |
| trig_o | output | 1 | One-cycle pulse when the register holds its seed |
| mon_o | output | 1 | Even stream retimed by one half-rate cycle |

## Verification
The assertions assume that reset is the only way the register state is set. They also assume that clk_i runs freely with a steady duty cycle, so the trigger spacing counter and the monitor delay relation see one edge per cycle. The stimulus drives reset only between clock edges and releases it in the low phase, so no edge meets a changing reset. A mid-run reset is applied in the high phase and released in a later low phase. The serial output is sampled in the middle of each clock phase, so both interleaved bits are checked in every cycle against a separate full-rate reference over more than two full trigger intervals.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  parameter int unsigned PRBS_ORDER = 11;
  parameter int unsigned PRBS_TAP   = 9;
  parameter int unsigned PRBS_LANES = 2;
endpackage

// File: rtl/prbs_core.sv
module prbs_core #(
  parameter int unsigned ORDER = prbs_pkg::PRBS_ORDER,
  parameter int unsigned TAP   = prbs_pkg::PRBS_TAP,
  parameter int unsigned LANES = prbs_pkg::PRBS_LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [ORDER-1:0] state_o,
  output logic [LANES-1:0] lane_o
);
  logic [ORDER-1:0] state_q;
  logic [ORDER-1:0] chain [0:LANES];

  assign chain[0] = state_q;

  // one serial step per lane, chained in one cycle
  for (genvar g = 0; g < LANES; g++) begin : g_step
    assign chain[g+1] = {chain[g][ORDER-2:0], chain[g][ORDER-1] ^ chain[g][TAP-1]};
    assign lane_o[LANES-1-g] = state_q[ORDER-1-g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '1;
    else         state_q <= chain[LANES];
  end

  assign state_o = state_q;

  assert_state_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/prbs_trig.sv
module prbs_trig #(
  parameter int unsigned ORDER = prbs_pkg::PRBS_ORDER
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ORDER-1:0] state_i,
  output logic             trig_o
);
  localparam int unsigned PERIOD = (1 << ORDER) - 1;

  assign trig_o = (state_i == '1);

  // spacing checker
  logic             seen_q;
  logic [ORDER-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      if (trig_o) begin
        seen_q <= 1'b1;
        gap_q  <= '0;
      end else begin
        gap_q  <= gap_q + 1'b1;
      end
    end
  end

  assert_trig_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  assert_trig_not_early_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && trig_o) |-> (gap_q == ORDER'(PERIOD - 1)));
  assert_trig_not_late_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && gap_q == ORDER'(PERIOD - 1)) |-> trig_o);
endmodule

// File: rtl/prbs_out.sv
module prbs_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic even_i,
  input  logic odd_i,
  output logic ser_o,
  output logic mon_o
);
  // clock level steers the 2:1 selector: high phase = even position
  assign ser_o = clk_i ? even_i : odd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mon_o <= 1'b0;
    else         mon_o <= even_i;
  end

  assert_mon_delay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (mon_o == $past(even_i)));
endmodule

// File: rtl/prbs_hr_gen.sv
module prbs_hr_gen #(
  parameter int unsigned ORDER = prbs_pkg::PRBS_ORDER,
  parameter int unsigned TAP   = prbs_pkg::PRBS_TAP
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic even_o,
  output logic odd_o,
  output logic ser_o,
  output logic trig_o,
  output logic mon_o
);
  localparam int unsigned LANES = 2;

  logic [ORDER-1:0] state;
  logic [LANES-1:0] lane;

  prbs_core #(.ORDER(ORDER), .TAP(TAP), .LANES(LANES)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (state),
    .lane_o  (lane)
  );

  assign even_o = lane[1];
  assign odd_o  = lane[0];

  prbs_trig #(.ORDER(ORDER)) u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .trig_o  (trig_o)
  );

  prbs_out u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .even_i (even_o),
    .odd_i  (odd_o),
    .ser_o  (ser_o),
    .mon_o  (mon_o)
  );
endmodule

// File: tb/prbs_hr_gen_tb_top.sv
module prbs_hr_gen_tb_top;
  localparam int PERIOD = 2047;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic even_w, odd_w, ser_w, trig_w, mon_w;

  always #4 clk = ~clk;

  prbs_hr_gen dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .even_o (even_w),
    .odd_o  (odd_w),
    .ser_o  (ser_w),
    .trig_o (trig_w),
    .mon_o  (mon_w)
  );

  int n_chk = 0;
  int n_fail = 0;

  // {even, odd, trig} for cycles 0..15, from b[n+11] = b[n] ^ b[n+2]
  localparam logic [2:0] VEC [0:15] = '{
    3'b111, 3'b110, 3'b110, 3'b110, 3'b110, 3'b100, 3'b000, 3'b000,
    3'b000, 3'b000, 3'b110, 3'b000, 3'b000, 3'b000, 3'b010, 3'b110
  };

  logic [10:0] ref_q;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ref_bit(output logic b);
    b = ref_q[10];
    ref_q = {ref_q[9:0], ref_q[10] ^ ref_q[8]};
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 1'b0;
    #1;
    chk("R1 even in reset", 32'(even_w), 1);
    chk("R1 odd in reset",  32'(odd_w),  1);
    chk("R1 trig in reset", 32'(trig_w), 1);
    chk("R1 mon in reset",  32'(mon_w),  0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #2;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic be, bo, prev_even;
    int last_trig;
    rst_n = 1'b0;
    #13;
    chk("R1 reset even", 32'(even_w), 1);
    chk("R1 reset trig", 32'(trig_w), 1);
    @(negedge clk);
    rst_n = 1'b1;
    #2;

    // table walk: cycle 0 sampled in low phase, later ones in high phase
    for (int i = 0; i < 16; i++) begin
      if (i > 0) begin @(posedge clk); #2; end
      chk("R2 table even", 32'(even_w), 32'(VEC[i][2]));
      chk("R2 table odd",  32'(odd_w),  32'(VEC[i][1]));
      chk("R5 table trig", 32'(trig_w), 32'(VEC[i][0]));
      if (i == 0) chk("R1 mon first cycle", 32'(mon_w), 0);
      else        chk("R6 table mon", 32'(mon_w), 32'(VEC[i-1][2]));
    end

    // R7: mid-run async reset, then long run against serial reference
    do_reset();
    ref_q = '1;
    ref_bit(be); ref_bit(bo);
    chk("R1 cycle0 even", 32'(even_w), 32'(be));
    chk("R3 cycle0 ser low", 32'(ser_w), 32'(bo));
    chk("R7 restart trig", 32'(trig_w), 1);
    prev_even = be;
    last_trig = 0;
    for (int k = 1; k <= 2 * PERIOD + 4; k++) begin
      @(posedge clk); #2;
      ref_bit(be); ref_bit(bo);
      chk("R3 ser high phase", 32'(ser_w), 32'(be));
      chk("R2 even", 32'(even_w), 32'(be));
      chk("R6 mon", 32'(mon_w), 32'(prev_even));
      chk("R5 trig", 32'(trig_w), 32'((k % PERIOD) == 0));
      if (trig_w) begin
        chk("R5 spacing", 32'(k - last_trig), PERIOD);
        last_trig = k;
      end
      if (k == 1023) chk("R4 wrap bit", 32'(odd_w), 1);
      #4;
      chk("R3 ser low phase", 32'(ser_w), 32'(bo));
      chk("R2 odd", 32'(odd_w), 32'(bo));
      prev_even = be;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule